// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked host and an external 4096-word by 4-bit asynchronous static RAM whose data pins are shared between reading and writing. The host offers one word per request over a valid/ready handshake: a 12-bit address, a 4-bit write value and a direction flag. The sequencer then drives the memory's address lines and its three active-low strobes (chip enable, write enable, output enable), plus an enable for its own data drivers, holding each phase for a whole number of clock cycles so that access time, write pulse width, data setup and bus turnaround are all met.

Every wait count is derived at elaboration from the clock period and the memory's timing figures, each rounded up to whole cycles. The defaults describe a 10 ns clock driving a 25 ns part. With those defaults a read keeps its strobes low for 3 cycles. A write keeps write enable low for 2 cycles. The bus is given 1 cycle to turn around after each transfer. Read data comes back in a register, marked by a single-cycle valid pulse.

All memory-side outputs come straight from flops, so no strobe can glitch. While this block drives the data pins, the memory is always held in its output-inhibit state.

Top module: `async_sram_ctl`

## Requirements
- R1: `reqReady` is high whenever the sequencer is idle. A request is taken on a clock edge where both `reqValid` and `reqReady` are high. `reqReady` then stays low until the whole access, including its turnaround cycle, has finished.
- R2: A read drives the address and pulls `memCeN` and `memOeN` low on the accepting edge, with `memWeN` high. All of these stay unchanged for RD_CYC cycles (3 by default).
- R3: Read data is registered from `memDin` at the end of the last access cycle. `rspValid` is high for exactly one cycle, the cycle after the strobes are released (3 cycles after acceptance by default), and `rspRdata` holds the data during that cycle.
- R4: After a read releases its strobes, `reqReady` returns after TURN_CYC cycles (1 by default). `memDoutEn` is never high while `memOeN` is low.
- R5: During a write, `memCeN` is low and `memOeN` stays high throughout (output inhibit). `memWeN` is never low while `memOeN` is low.
- R6: In a write, `memWeN` falls one cycle after the address and `memCeN` were set. `memDoutEn` is low in the cycle `memWeN` falls and rises WZ_CYC cycles later (1 by default).
- R7: `memWeN` stays low for at least WP_CYC cycles (2 by default). `memDout` is driven for at least DW_CYC cycles (1 by default) before `memWeN` rises.
- R8: `memWeN` and `memCeN` rise on the same edge. `memDoutEn` is still high in that cycle and drops one cycle later, in the same cycle that `reqReady` returns high.
- R9: `memAddr` does not change while `memCeN` stays low.
- R10: During and right after reset, `memCeN`, `memWeN` and `memOeN` are 1, `memDoutEn` and `rspValid` are 0, and `reqReady` is 1.
- R11: A request held valid while the sequencer is busy is not taken: the address and strobes of the current access are unaffected. It is accepted on the first edge on which `reqReady` is high.
- R12: Every one of the 4096 addresses returns the value most recently written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Sequencer can take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 12 | Word address |
| reqWdata | input | 4 | Value to write |
| rspValid | output | 1 | One-cycle pulse marking read data |
| rspRdata | output | 4 | Registered read data |
| memAddr | output | 12 | Memory address lines |
| memCeN | output | 1 | Memory chip enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memDout | output | 4 | Value for the shared data pins |
| memDoutEn | output | 1 | Enable for the data-pin drivers |
| memDin | input | 4 | Value read back from the shared data pins |

## Verification
The bound checker watches the bus rules on every cycle:
- the data drivers are never on while output enable is low;
- write enable is only ever low in the output-inhibit state;
- the drivers are off when write enable falls and still on when it rises;
- the address is steady under chip enable;
- the response pulse lasts one cycle;
- counted pulse widths for the read and write strobes never fall short of their minimums.

Only the bench scenarios can show the rest. These cover the exact cycle on which each strobe moves and when data is sampled against a memory model that returns wrong data before the access time has passed. They also cover the handling of a request held during a busy access, and the integrity of data across all 4096 addresses.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  // Sequencer phases
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_TURN,
    ST_WR_SETUP,
    ST_WR_WZ,
    ST_WR_DATA,
    ST_WR_HOLD
  } ctlState_t;

  // Registered memory-side strobes (active-low except the driver enable)
  typedef struct packed {
    logic ceN;
    logic weN;
    logic oeN;
    logic doutEn;
  } busStrobes_t;

  // Control to datapath
  typedef struct packed {
    logic loadReq;
    logic capRead;
  } dpCtl_t;

  // Whole cycles covering a time, never less than one
  function automatic int cyclesFor(input int timePs, input int clkPs);
    int c;
    c = (timePs + clkPs - 1) / clkPs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic [DATA_W-1:0] rspRdata
);

  // Address and write value are latched once per access and held
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
      memDout <= '0;
    end else if (ctl.loadReq) begin
      memAddr <= reqAddr;
      memDout <= reqWdata;
    end
  end

  // Read capture on the last access cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspRdata <= '0;
    end else if (ctl.capRead) begin
      rspRdata <= memDin;
    end
  end

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int RD_CYC   = 3,
  parameter int TURN_CYC = 1,
  parameter int WZ_CYC   = 1,
  parameter int DATA_CYC = 1,
  parameter int CNT_W    = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        reqReady,
  output logic        rspValid,
  output busStrobes_t strobes,
  output dpCtl_t      dpCtl
);

  ctlState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             cntDone;

  always_comb begin
    reqReady      = (state == ST_IDLE);
    accept        = reqValid && reqReady;
    cntDone       = (cnt == '0);
    dpCtl.loadReq = accept;
    dpCtl.capRead = (state == ST_RD_ACC) && cntDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      strobes  <= '{ceN: 1'b1, weN: 1'b1, oeN: 1'b1, doutEn: 1'b0};
      rspValid <= 1'b0;
    end else begin
      rspValid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            strobes.ceN <= 1'b0;
            if (reqWrite) begin
              state <= ST_WR_SETUP;
            end else begin
              strobes.oeN <= 1'b0;
              cnt         <= CNT_W'(RD_CYC - 1);
              state       <= ST_RD_ACC;
            end
          end
        end
        ST_RD_ACC: begin
          if (cntDone) begin
            strobes.ceN <= 1'b1;
            strobes.oeN <= 1'b1;
            rspValid    <= 1'b1;
            cnt         <= CNT_W'(TURN_CYC - 1);
            state       <= ST_RD_TURN;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RD_TURN: begin
          if (cntDone) state <= ST_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        ST_WR_SETUP: begin
          strobes.weN <= 1'b0;
          cnt         <= CNT_W'(WZ_CYC - 1);
          state       <= ST_WR_WZ;
        end
        ST_WR_WZ: begin
          if (cntDone) begin
            strobes.doutEn <= 1'b1;
            cnt            <= CNT_W'(DATA_CYC - 1);
            state          <= ST_WR_DATA;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WR_DATA: begin
          if (cntDone) begin
            strobes.weN <= 1'b1;
            strobes.ceN <= 1'b1;
            state       <= ST_WR_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WR_HOLD: begin
          strobes.doutEn <= 1'b0;
          state          <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/async_sram_ctl.sv
module async_sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 4,
  parameter int CLK_PS    = 10000,
  parameter int T_ACC_PS  = 25000,
  parameter int T_RC_PS   = 25000,
  parameter int T_HZ_PS   = 10000,
  parameter int T_WP_PS   = 20000,
  parameter int T_DW_PS   = 10000,
  parameter int T_WZ_PS   = 7000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  localparam int RD_CYC   = maxOf(cyclesFor(T_ACC_PS, CLK_PS), cyclesFor(T_RC_PS, CLK_PS));
  localparam int TURN_CYC = cyclesFor(T_HZ_PS, CLK_PS);
  localparam int WZ_CYC   = cyclesFor(T_WZ_PS, CLK_PS);
  localparam int WP_CYC   = cyclesFor(T_WP_PS, CLK_PS);
  localparam int DW_CYC   = cyclesFor(T_DW_PS, CLK_PS);
  localparam int DATA_CYC = maxOf(DW_CYC, WP_CYC - WZ_CYC);
  localparam int MAX_CYC  = maxOf(maxOf(RD_CYC, TURN_CYC), maxOf(WZ_CYC, DATA_CYC));
  localparam int CNT_W    = maxOf(1, $clog2(MAX_CYC));

  busStrobes_t strobes;
  dpCtl_t      dpCtl;

  sram_ctl_fsm #(
    .RD_CYC   (RD_CYC),
    .TURN_CYC (TURN_CYC),
    .WZ_CYC   (WZ_CYC),
    .DATA_CYC (DATA_CYC),
    .CNT_W    (CNT_W)
  ) i_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .strobes  (strobes),
    .dpCtl    (dpCtl)
  );

  sram_ctl_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (dpCtl),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memDin   (memDin),
    .memAddr  (memAddr),
    .memDout  (memDout),
    .rspRdata (rspRdata)
  );

  assign memCeN    = strobes.ceN;
  assign memWeN    = strobes.weN;
  assign memOeN    = strobes.oeN;
  assign memDoutEn = strobes.doutEn;

endmodule

// File: rtl/async_sram_ctl_chk.sv
module async_sram_ctl_chk #(
  parameter int ADDR_W = 12,
  parameter int RD_MIN = 3,
  parameter int WE_MIN = 2,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memDoutEn
);

  logic [CNT_W-1:0] weLowCnt;
  logic [CNT_W-1:0] oeLowCnt;

  // Saturating low-time counters for the pulse-width checks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLowCnt <= '0;
      oeLowCnt <= '0;
    end else begin
      if (memWeN) weLowCnt <= '0;
      else if (weLowCnt != '1) weLowCnt <= weLowCnt + 1'b1;
      if (memOeN) oeLowCnt <= '0;
      else if (oeLowCnt != '1) oeLowCnt <= oeLowCnt + 1'b1;
    end
  end

  assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rstN)
    !memCeN |-> !reqReady);

  assert_read_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |-> (oeLowCnt >= CNT_W'(RD_MIN)));

  assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDoutEn);

  assert_write_inhibit_R5: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memOeN && !memCeN));

  assert_we_fall_drivers_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> !memDoutEn);

  assert_we_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowCnt >= CNT_W'(WE_MIN)));

  assert_data_held_at_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (memDoutEn && $rose(memCeN)));

  assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

endmodule

bind async_sram_ctl async_sram_ctl_chk #(
  .ADDR_W (ADDR_W),
  .RD_MIN (RD_CYC),
  .WE_MIN (WP_CYC)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqReady  (reqReady),
  .rspValid  (rspValid),
  .memAddr   (memAddr),
  .memCeN    (memCeN),
  .memWeN    (memWeN),
  .memOeN    (memOeN),
  .memDoutEn (memDoutEn)
);

// File: tb/test_async_sram_ctl.sv
module test_async_sram_ctl;

  localparam int AW      = 12;
  localparam int DW      = 4;
  localparam int WORDS   = 1 << AW;
  localparam int RD_WAIT = (25000 + 9999) / 10000;  // 3 access cycles
  localparam int WP_MIN  = (20000 + 9999) / 10000;  // 2 write-pulse cycles

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          rspValid;
  logic [DW-1:0] rspRdata;
  logic [AW-1:0] memAddr;
  logic          memCeN, memWeN, memOeN, memDoutEn;
  logic [DW-1:0] memDout;
  logic [DW-1:0] memDin = '0;

  int  nVec  = 0;
  int  nFail = 0;
  bit  done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  async_sram_ctl i_async_sram_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .memAddr(memAddr),
    .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN), .memDout(memDout),
    .memDoutEn(memDoutEn), .memDin(memDin)
  );

  task automatic chkEq(input string req, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int seed);
    return DW'((a * 7 + (a >> 5) + seed) & 4'hF);
  endfunction

  // ---------------- memory model (sampled at negedge) ----------------
  logic [DW-1:0] mem [WORDS];
  logic [AW-1:0] prevAddr = '0;
  logic          prevWeN = 1'b1;
  logic          prevDoutEn = 1'b0;
  int            accCnt = 0;
  int            weLow = 0;

  initial for (int i = 0; i < WORDS; i++) mem[i] = '0;

  always @(negedge clk) begin
    if (rstN) begin
      // R4: driver must never fight the memory's output
      if (!memOeN && !memCeN && memDoutEn) chkEq("R4 contention", 1, 0);
      // Access counter: strobes low, write high, address unchanged
      if (!memCeN && !memOeN && memWeN)
        accCnt = (memAddr == prevAddr) ? accCnt + 1 : 1;
      else
        accCnt = 0;
      memDin <= (accCnt >= RD_WAIT) ? mem[memAddr] : ~mem[memAddr];
      // Write completes on write-enable rise
      if (!prevWeN && memWeN) begin
        chkEq("R7 we low width ok", int'(weLow >= WP_MIN), 1);
        chkEq("R7 data driven before rise", int'(prevDoutEn), 1);
        mem[memAddr] = memDout;
      end
      weLow = memWeN ? 0 : weLow + 1;
      prevWeN    = memWeN;
      prevDoutEn = memDoutEn;
      prevAddr   = memAddr;
    end
  end

  // ---------------- transaction tasks (called at a negedge) -----------
  task automatic waitReady();
    int n = 0;
    while (!reqReady && n < 50) begin @(negedge clk); n++; end
  endtask

  task automatic doWrite(input int a, input logic [DW-1:0] d);
    waitReady();
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = AW'(a); reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    waitReady();
  endtask

  task automatic doRead(input int a, input logic [DW-1:0] exp);
    int lat = 0;
    waitReady();
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = AW'(a);
    @(negedge clk);
    reqValid = 1'b0;
    while (!rspValid && lat < 20) begin @(negedge clk); lat++; end
    chkEq("R3 read latency", lat, RD_WAIT);
    chkEq("R12 read data", int'(rspRdata), int'(exp));
    waitReady();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      nVec++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chkEq("R10 ceN", int'(memCeN), 1);
    chkEq("R10 weN", int'(memWeN), 1);
    chkEq("R10 oeN", int'(memOeN), 1);
    chkEq("R10 doutEn", int'(memDoutEn), 0);
    chkEq("R10 rspValid", int'(rspValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R10 ready after reset", int'(reqReady), 1);

    // Directed write: 0xA5C <- 9
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 12'hA5C; reqWdata = 4'h9;
    @(negedge clk);  // n0
    reqValid = 1'b0;
    chkEq("R5 ceN low", int'(memCeN), 0);
    chkEq("R5 oeN high", int'(memOeN), 1);
    chkEq("R6 weN before fall", int'(memWeN), 1);
    chkEq("R1 ready low", int'(reqReady), 0);
    chkEq("R9 addr", int'(memAddr), 12'hA5C);
    @(negedge clk);  // n1
    chkEq("R6 weN fell", int'(memWeN), 0);
    chkEq("R6 drivers off at fall", int'(memDoutEn), 0);
    @(negedge clk);  // n2
    chkEq("R6 drivers on", int'(memDoutEn), 1);
    chkEq("R7 weN still low", int'(memWeN), 0);
    chkEq("R7 dout", int'(memDout), 4'h9);
    chkEq("R5 oeN high in pulse", int'(memOeN), 1);
    @(negedge clk);  // n3
    chkEq("R8 weN rose", int'(memWeN), 1);
    chkEq("R8 ceN rose", int'(memCeN), 1);
    chkEq("R8 drivers held", int'(memDoutEn), 1);
    chkEq("R1 still busy", int'(reqReady), 0);
    @(negedge clk);  // n4
    chkEq("R8 drivers released", int'(memDoutEn), 0);
    chkEq("R8 ready back", int'(reqReady), 1);

    // Directed read of 0xA5C with a write held valid while busy
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 12'hA5C;
    @(negedge clk);  // n0
    reqWrite = 1'b1; reqAddr = 12'h0F3; reqWdata = 4'h5;  // stays valid
    chkEq("R2 ceN", int'(memCeN), 0);
    chkEq("R2 oeN", int'(memOeN), 0);
    chkEq("R2 weN", int'(memWeN), 1);
    chkEq("R1 ready low", int'(reqReady), 0);
    @(negedge clk);  // n1
    chkEq("R11 addr held", int'(memAddr), 12'hA5C);
    chkEq("R2 oeN held", int'(memOeN), 0);
    @(negedge clk);  // n2
    chkEq("R11 addr held", int'(memAddr), 12'hA5C);
    chkEq("R11 weN untouched", int'(memWeN), 1);
    chkEq("R3 no early rsp", int'(rspValid), 0);
    @(negedge clk);  // n3
    chkEq("R3 rspValid", int'(rspValid), 1);
    chkEq("R3 rspRdata", int'(rspRdata), 4'h9);
    chkEq("R2 strobes released", int'({memCeN, memOeN}), 3);
    chkEq("R4 ready in turnaround", int'(reqReady), 0);
    @(negedge clk);  // n4
    chkEq("R4 ready after turnaround", int'(reqReady), 1);
    chkEq("R3 pulse one cycle", int'(rspValid), 0);
    chkEq("R11 not accepted yet", int'(memCeN), 1);
    @(negedge clk);  // n5: held write taken
    reqValid = 1'b0;
    chkEq("R11 accepted addr", int'(memAddr), 12'h0F3);
    chkEq("R11 accepted ceN", int'(memCeN), 0);
    waitReady();
    doRead(12'h0F3, 4'h5);

    // R12: exhaustive sweep, then partial overwrite
    for (int a = 0; a < WORDS; a++) doWrite(a, pat(a, 0));
    for (int a = 0; a < WORDS; a++) doRead(a, pat(a, 0));
    for (int a = 0; a < WORDS; a += 17) doWrite(a, pat(a, 9));
    for (int a = 0; a < WORDS; a += 1) begin
      if (a % 17 == 0) doRead(a, pat(a, 9));
      else if (a % 64 == 1) doRead(a, pat(a, 0));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

endmodule